// File: doc/BRIEF.md
# Receiver Eye Opening Scanner

This block measures how wide and how tall the open region of a serial receiver's data eye is. Next to the normal recovered-data sampler sits a second sampler whose phase offset and decision threshold this block drives. The block visits every point of a phase-by-threshold grid. At each point it counts the bits on which the two samplers disagree over a programmable window. A point whose mismatch count stays within a programmable limit is marked open in a one-bit-per-point map.

When the sweep ends, the block turns the longest run of open points along any threshold row into a horizontal percentage. It turns the longest run along any phase column into a vertical percentage. Each percentage is compared with a programmed minimum, which gives a pass or fail flag for each axis. If the receiver is not locked when a scan is requested, or loses lock during one, the block reports a no-lock status instead of results. After the scan, the map can be read one point at a time through an address port.

The controller is a five-state machine:
- `ST_IDLE` waits for `start`. With lock present it goes to `ST_SETTLE`. Without lock it goes to `ST_FINISH`.
- `ST_SETTLE` waits out the settle time and then goes to `ST_DWELL`.
- `ST_DWELL` counts mismatches until the window is full and then goes to `ST_RECORD`.
- `ST_RECORD` stores the point and steps the grid. It returns to `ST_SETTLE`, or goes to `ST_FINISH` after the last point.
- `ST_FINISH` publishes the results for one cycle and returns to `ST_IDLE`.
- From `ST_SETTLE`, `ST_DWELL` or `ST_RECORD`, a low lock input goes straight to `ST_FINISH` with the scan marked as aborted.

Top module: `eye_scan_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `nolock` are 0, both offset selects are 0, and all result outputs are 0.
- R2: A one-cycle `start` with `cdr_lock` high raises `busy` on the next cycle. `busy` stays high until the scan ends. `done` then pulses for exactly one cycle, with `busy` already low in that cycle.
- R3: The grid is 32 phase steps by 32 threshold steps. It is visited with the threshold in the inner loop and the phase in the outer loop. Each step is either (p, t+1) or (p+1, 0), starting at (0, 0). Each point holds its selects for `cfg_settle`+1 settle cycles, then `cfg_dwell` compare cycles, then one record cycle: `cfg_settle`+`cfg_dwell`+2 cycles in all.
- R4: A point is open when the count of cycles with `main_bit` != `offs_bit` during its compare window is at most `cfg_err_lim`. Mismatches during the settle cycles are not counted.
- R5: `map_rd_data` returns the flag of the point at address phase*32 + threshold: 1 for open, 0 for closed. The map is cleared when a scan starts.
- R6: `heo_pct` is floor(L*100/32). L is the longest run of consecutive open points across phases at any single threshold.
- R7: `veo_pct` is floor(L*100/32). L is the longest run of consecutive open points across thresholds at any single phase.
- R8: `h_pass` is 1 only when `heo_pct` >= `cfg_hmin`, and `v_pass` only when `veo_pct` >= `cfg_vmin`. Equality passes.
- R9: A `start` while `cdr_lock` is low performs no scan. `busy` stays low, and `done` pulses two cycles later with `nolock`=1, both percentages 0 and both pass flags 0.
- R10: If `cdr_lock` falls during a scan, the scan is abandoned. `busy` falls within two cycles, and `done` reports `nolock`=1 with zero results.
- R11: A `start` pulse while `busy` is high is ignored. The running scan continues, and exactly one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Scan request pulse |
| cdr_lock | input | 1 | Receiver lock indication |
| main_bit | input | 1 | Bit from the recovered-data sampler |
| offs_bit | input | 1 | Bit from the offset sampler |
| cfg_settle | input | 16 | Settle cycles after a step, minus one |
| cfg_dwell | input | 16 | Compare cycles per point |
| cfg_err_lim | input | 16 | Largest mismatch count still counted as open |
| cfg_hmin | input | 7 | Horizontal pass minimum, percent |
| cfg_vmin | input | 7 | Vertical pass minimum, percent |
| phase_sel | output | 5 | Offset sampler phase step |
| thresh_sel | output | 5 | Offset sampler threshold step |
| map_addr | input | 10 | Map read address, phase*32+threshold |
| map_rd_data | output | 1 | Open flag at `map_addr` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result-valid pulse |
| nolock | output | 1 | Last scan missing lock or aborted |
| heo_pct | output | 7 | Horizontal opening, percent |
| veo_pct | output | 7 | Vertical opening, percent |
| h_pass | output | 1 | Horizontal opening meets minimum |
| v_pass | output | 1 | Vertical opening meets minimum |

## Verification
A wrong step counter or settle count appears at the selects within the first point, about twenty cycles into a scan. It shows as a hold length other than settle+dwell+2, or as a step out of threshold-inner order. A wrong mismatch count or limit comparison stays hidden until the sweep ends. It then shows as a shifted percentage or pass flag, and as a wrong map bit at a marginal point. The test eye has a cross-shaped open region with marginal edges that fail only one in eight compares, so row-versus-column mix-ups and limit errors change different figures. A broken lock path shows within two cycles, as `busy` failing to drop or as a `done` without `nolock`.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_DWELL,
        ST_RECORD,
        ST_FINISH
    } scan_state_t;

endpackage

// File: rtl/eye_point_meter.sv
module eye_point_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             main_bit,
    input  logic             offs_bit,
    input  logic [CNT_W-1:0] dwell_len,
    input  logic [CNT_W-1:0] err_lim,
    output logic             last_cmp,
    output logic             pt_open
);

    logic [CNT_W-1:0] cmp_cnt;
    logic [CNT_W-1:0] err_cnt;
    logic             mism;

    assign mism     = main_bit ^ offs_bit;
    assign last_cmp = en && ((dwell_len == '0) || (cmp_cnt == dwell_len - CNT_W'(1)));
    assign pt_open  = (err_cnt <= err_lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_cnt <= '0;
            err_cnt <= '0;
        end else if (clr) begin
            cmp_cnt <= '0;
            err_cnt <= '0;
        end else if (en) begin
            cmp_cnt <= cmp_cnt + CNT_W'(1);
            if (mism && (err_cnt != '1))
                err_cnt <= err_cnt + CNT_W'(1);
        end
    end

    // R4
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= cmp_cnt);

endmodule

// File: rtl/eye_run_tracker.sv
module eye_run_tracker #(
    parameter int PH_STEPS = 32,
    parameter int TH_STEPS = 32,
    parameter int TH_W     = 5,
    parameter int RUN_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             pt_open,
    input  logic             th_last,
    input  logic [TH_W-1:0]  th_idx,
    output logic [RUN_W-1:0] h_best,
    output logic [RUN_W-1:0] v_best
);

    logic [RUN_W-1:0] h_run [TH_STEPS];
    logic [RUN_W-1:0] v_run;
    logic [RUN_W-1:0] h_next;
    logic [RUN_W-1:0] v_next;

    for (genvar g = 0; g < TH_STEPS; g++) begin : g_row
        logic [RUN_W-1:0] run_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                run_q <= '0;
            else if (clr)
                run_q <= '0;
            else if (upd && (th_idx == TH_W'(g)))
                run_q <= pt_open ? run_q + RUN_W'(1) : '0;
        end
        assign h_run[g] = run_q;
    end

    assign h_next = pt_open ? h_run[th_idx] + RUN_W'(1) : '0;
    assign v_next = pt_open ? v_run + RUN_W'(1) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_run  <= '0;
            v_best <= '0;
            h_best <= '0;
        end else if (clr) begin
            v_run  <= '0;
            v_best <= '0;
            h_best <= '0;
        end else if (upd) begin
            v_run <= th_last ? '0 : v_next;
            if (v_next > v_best) v_best <= v_next;
            if (h_next > h_best) h_best <= h_next;
        end
    end

    // R6
    h_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_best <= RUN_W'(PH_STEPS));

    // R7
    v_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_best <= RUN_W'(TH_STEPS));

endmodule

// File: rtl/eye_pct_calc.sv
module eye_pct_calc #(
    parameter int DIM   = 32,
    parameter int RUN_W = 6,
    parameter int PCT_W = 7
) (
    input  logic [RUN_W-1:0] run_len,
    output logic [PCT_W-1:0] pct
);

    localparam int PROD_W = RUN_W + 7;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    assign prod = PROD_W'(run_len) * PROD_W'(100);
    assign quot = prod / PROD_W'(DIM);
    assign pct  = PCT_W'(quot);

endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl
    import eye_scan_pkg::*;
#(
    parameter int PH_STEPS = 32,
    parameter int TH_STEPS = 32,
    parameter int CNT_W    = 16,
    parameter int PCT_W    = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic                                  cdr_lock,
    input  logic                                  main_bit,
    input  logic                                  offs_bit,
    input  logic [CNT_W-1:0]                      cfg_settle,
    input  logic [CNT_W-1:0]                      cfg_dwell,
    input  logic [CNT_W-1:0]                      cfg_err_lim,
    input  logic [PCT_W-1:0]                      cfg_hmin,
    input  logic [PCT_W-1:0]                      cfg_vmin,
    output logic [$clog2(PH_STEPS)-1:0]           phase_sel,
    output logic [$clog2(TH_STEPS)-1:0]           thresh_sel,
    input  logic [$clog2(PH_STEPS*TH_STEPS)-1:0]  map_addr,
    output logic                                  map_rd_data,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  nolock,
    output logic [PCT_W-1:0]                      heo_pct,
    output logic [PCT_W-1:0]                      veo_pct,
    output logic                                  h_pass,
    output logic                                  v_pass
);

    localparam int PH_W   = $clog2(PH_STEPS);
    localparam int TH_W   = $clog2(TH_STEPS);
    localparam int MAP_N  = PH_STEPS * TH_STEPS;
    localparam int ADDR_W = $clog2(MAP_N);
    localparam int MAXDIM = (PH_STEPS > TH_STEPS) ? PH_STEPS : TH_STEPS;
    localparam int RUN_W  = $clog2(MAXDIM + 1);

    scan_state_t      state, state_nx;
    logic [PH_W-1:0]  ph_idx;
    logic [TH_W-1:0]  th_idx;
    logic [CNT_W-1:0] settle_cnt;
    logic             aborted;
    logic [MAP_N-1:0] map_bits;
    logic [ADDR_W-1:0] wr_addr;

    logic             last_cmp;
    logic             pt_open;
    logic             th_last;
    logic             grid_last;
    logic             scan_go;
    logic             trk_upd;
    logic [RUN_W-1:0] h_best;
    logic [RUN_W-1:0] v_best;
    logic [PCT_W-1:0] h_pct;
    logic [PCT_W-1:0] v_pct;

    assign th_last   = (th_idx == TH_W'(TH_STEPS - 1));
    assign grid_last = th_last && (ph_idx == PH_W'(PH_STEPS - 1));
    assign scan_go   = (state == ST_IDLE) && start;
    assign trk_upd   = (state == ST_RECORD) && cdr_lock;
    assign wr_addr   = ADDR_W'(ph_idx) * ADDR_W'(TH_STEPS) + ADDR_W'(th_idx);

    assign phase_sel   = ph_idx;
    assign thresh_sel  = th_idx;
    assign map_rd_data = map_bits[map_addr];

    eye_point_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state == ST_SETTLE),
        .en        (state == ST_DWELL),
        .main_bit  (main_bit),
        .offs_bit  (offs_bit),
        .dwell_len (cfg_dwell),
        .err_lim   (cfg_err_lim),
        .last_cmp  (last_cmp),
        .pt_open   (pt_open)
    );

    eye_run_tracker #(
        .PH_STEPS (PH_STEPS),
        .TH_STEPS (TH_STEPS),
        .TH_W     (TH_W),
        .RUN_W    (RUN_W)
    ) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (scan_go),
        .upd     (trk_upd),
        .pt_open (pt_open),
        .th_last (th_last),
        .th_idx  (th_idx),
        .h_best  (h_best),
        .v_best  (v_best)
    );

    eye_pct_calc #(.DIM(PH_STEPS), .RUN_W(RUN_W), .PCT_W(PCT_W)) u_hpct (
        .run_len (h_best),
        .pct     (h_pct)
    );

    eye_pct_calc #(.DIM(TH_STEPS), .RUN_W(RUN_W), .PCT_W(PCT_W)) u_vpct (
        .run_len (v_best),
        .pct     (v_pct)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = cdr_lock ? ST_SETTLE : ST_FINISH;
            end
            ST_SETTLE: begin
                if (!cdr_lock)                      state_nx = ST_FINISH;
                else if (settle_cnt == cfg_settle)  state_nx = ST_DWELL;
            end
            ST_DWELL: begin
                if (!cdr_lock)     state_nx = ST_FINISH;
                else if (last_cmp) state_nx = ST_RECORD;
            end
            ST_RECORD: begin
                if (!cdr_lock || grid_last) state_nx = ST_FINISH;
                else                        state_nx = ST_SETTLE;
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_idx     <= '0;
            th_idx     <= '0;
            settle_cnt <= '0;
            aborted    <= 1'b0;
            map_bits   <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            nolock     <= 1'b0;
            heo_pct    <= '0;
            veo_pct    <= '0;
            h_pass     <= 1'b0;
            v_pass     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ph_idx     <= '0;
                        th_idx     <= '0;
                        settle_cnt <= '0;
                        map_bits   <= '0;
                        aborted    <= !cdr_lock;
                        busy       <= cdr_lock;
                    end
                end
                ST_SETTLE: begin
                    if (!cdr_lock) aborted <= 1'b1;
                    settle_cnt <= settle_cnt + CNT_W'(1);
                end
                ST_DWELL: begin
                    if (!cdr_lock) aborted <= 1'b1;
                end
                ST_RECORD: begin
                    if (!cdr_lock) begin
                        aborted <= 1'b1;
                    end else begin
                        map_bits[wr_addr] <= pt_open;
                        settle_cnt        <= '0;
                        if (!grid_last) begin
                            if (th_last) begin
                                th_idx <= '0;
                                ph_idx <= ph_idx + PH_W'(1);
                            end else begin
                                th_idx <= th_idx + TH_W'(1);
                            end
                        end
                    end
                end
                ST_FINISH: begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    nolock  <= aborted;
                    heo_pct <= aborted ? '0 : h_pct;
                    veo_pct <= aborted ? '0 : v_pct;
                    h_pass  <= !aborted && (h_pct >= cfg_hmin);
                    v_pass  <= !aborted && (v_pct >= cfg_vmin);
                end
                default: ;
            endcase
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DWELL && $past(state) == ST_DWELL) |-> ($stable(phase_sel) && $stable(thresh_sel)));

    // R9
    nolock_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nolock) |-> (heo_pct == '0 && veo_pct == '0 && !h_pass && !v_pass));

    // R6
    pct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (heo_pct <= PCT_W'(100) && veo_pct <= PCT_W'(100)));

    // R10
    lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cdr_lock && state != ST_FINISH) |-> ##2 !busy);

endmodule

// File: tb/eye_scan_ctrl_bench.sv
module eye_scan_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GRID       = 32;

    typedef struct {
        bit nolock;
        int heo;
        int veo;
        bit hp;
        bit vp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cdr_lock = 1'b1;
    logic        main_bit = 1'b0;
    logic        offs_bit = 1'b0;
    logic [15:0] cfg_settle = 16'd2;
    logic [15:0] cfg_dwell = 16'd16;
    logic [15:0] cfg_err_lim = 16'd0;
    logic [6:0]  cfg_hmin = 7'd0;
    logic [6:0]  cfg_vmin = 7'd0;
    logic [4:0]  phase_sel;
    logic [4:0]  thresh_sel;
    logic [9:0]  map_addr = 10'd0;
    logic        map_rd_data;
    logic        busy, done, nolock, h_pass, v_pass;
    logic [6:0]  heo_pct, veo_pct;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cyc = 0;
    int order_err = 0;
    int hold_err = 0;
    int step_cnt = 0;
    bit finished = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eye_scan_ctrl u_eye_scan_ctrl (
        .clk (clk), .rst_n (rst_n), .start (start), .cdr_lock (cdr_lock),
        .main_bit (main_bit), .offs_bit (offs_bit),
        .cfg_settle (cfg_settle), .cfg_dwell (cfg_dwell), .cfg_err_lim (cfg_err_lim),
        .cfg_hmin (cfg_hmin), .cfg_vmin (cfg_vmin),
        .phase_sel (phase_sel), .thresh_sel (thresh_sel),
        .map_addr (map_addr), .map_rd_data (map_rd_data),
        .busy (busy), .done (done), .nolock (nolock),
        .heo_pct (heo_pct), .veo_pct (veo_pct), .h_pass (h_pass), .v_pass (v_pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 closed, 1 open, 2 marginal (one mismatch in eight cycles)
    function automatic int pt_class(int p, int t);
        if (p >= 10 && p <= 21 && t >= 12 && t <= 19) return 1;
        if (t >= 15 && t <= 16 && p >= 4 && p <= 27) return 1;
        if (p == 15 && t >= 5 && t <= 26) return 1;
        if (t >= 15 && t <= 16 && p >= 28 && p <= 29) return 2;
        if (p == 15 && t >= 27 && t <= 28) return 2;
        return 0;
    endfunction

    function automatic bit pt_is_open(int p, int t, int lim);
        int c;
        c = pt_class(p, t);
        return (c == 1) || (c == 2 && lim >= 2);
    endfunction

    function automatic exp_t model(int lim, int hmin, int vmin);
        exp_t e;
        int bh, bv;
        bh = 0;
        bv = 0;
        for (int t = 0; t < GRID; t++) begin
            int run;
            run = 0;
            for (int p = 0; p < GRID; p++) begin
                run = pt_is_open(p, t, lim) ? run + 1 : 0;
                if (run > bh) bh = run;
            end
        end
        for (int p = 0; p < GRID; p++) begin
            int run;
            run = 0;
            for (int t = 0; t < GRID; t++) begin
                run = pt_is_open(p, t, lim) ? run + 1 : 0;
                if (run > bv) bv = run;
            end
        end
        e.nolock = 0;
        e.heo = bh * 100 / GRID;
        e.veo = bv * 100 / GRID;
        e.hp = (e.heo >= hmin);
        e.vp = (e.veo >= vmin);
        return e;
    endfunction

    // sampler stimulus
    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        forever begin
            int c;
            bit err;
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = pt_class(int'(phase_sel), int'(thresh_sel));
            err = (c == 0) ? 1'b1 : (c == 2) ? (cyc % 8 == 0) : 1'b0;
            main_bit = lfsr[0];
            offs_bit = lfsr[0] ^ err;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(nolock == e.nolock, "R9/R10 nolock", int'(nolock), int'(e.nolock));
                    chk(int'(heo_pct) == e.heo, "R6 heo_pct", int'(heo_pct), e.heo);
                    chk(int'(veo_pct) == e.veo, "R7 veo_pct", int'(veo_pct), e.veo);
                    chk(h_pass == e.hp, "R8 h_pass", int'(h_pass), int'(e.hp));
                    chk(v_pass == e.vp, "R8 v_pass", int'(v_pass), int'(e.vp));
                    chk(!busy, "R2 busy low at done", int'(busy), 0);
                end
                done_cnt++;
            end
        end
    end

    // sweep order and hold-length monitor (R3)
    initial begin
        int pp, pt, hold;
        bit pb;
        pp = 0; pt = 0; hold = 0; pb = 0;
        forever begin
            @(negedge clk);
            if (busy && !pb) begin
                hold = 1;
            end else if (busy && (int'(phase_sel) != pp || int'(thresh_sel) != pt)) begin
                if (!((int'(phase_sel) == pp && int'(thresh_sel) == pt + 1) ||
                      (int'(phase_sel) == pp + 1 && thresh_sel == 0)))
                    order_err++;
                if (hold != int'(cfg_settle) + int'(cfg_dwell) + 2)
                    hold_err++;
                step_cnt++;
                hold = 1;
            end else begin
                hold++;
            end
            pp = int'(phase_sel);
            pt = int'(thresh_sel);
            pb = busy;
        end
    end

    task automatic run_scan(input int lim, input int hmin, input int vmin, input bit stray);
        int d0;
        cfg_err_lim = 16'(lim);
        cfg_hmin = 7'(hmin);
        cfg_vmin = 7'(vmin);
        exp_q.push_back(model(lim, hmin, vmin));
        d0 = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (stray) begin
            repeat (500) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic map_check(input int p, input int t, input int lim);
        map_addr = 10'(p * GRID + t);
        @(negedge clk);
        chk(map_rd_data == pt_is_open(p, t, lim), "R4/R5 map bit",
            int'(map_rd_data), int'(pt_is_open(p, t, lim)));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        exp_t nl;
        nl.nolock = 1; nl.heo = 0; nl.veo = 0; nl.hp = 0; nl.vp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !nolock, "R1 flags after reset", int'({busy, done, nolock}), 0);
        chk(phase_sel == 0 && thresh_sel == 0, "R1 selects after reset",
            int'({phase_sel, thresh_sel}), 0);
        chk(heo_pct == 0 && veo_pct == 0 && !h_pass && !v_pass, "R1 results after reset",
            int'(heo_pct) + int'(veo_pct), 0);

        // scan A: no tolerance, heo 75 meets min exactly, veo 68 misses 69
        run_scan(0, 75, 69, 0);
        map_check(28, 15, 0);
        map_check(15, 27, 0);
        map_check(15, 15, 0);

        // scan B: tolerance 2, stray start mid-scan (R11)
        run_scan(2, 82, 75, 1);
        chk(step_cnt >= 2 * (GRID * GRID - 1), "R3 step count", step_cnt, 2 * (GRID * GRID - 1));
        chk(order_err == 0, "R3 sweep order", order_err, 0);
        chk(hold_err == 0, "R3 hold length", hold_err, 0);
        map_check(28, 15, 2);
        map_check(29, 16, 2);
        map_check(30, 16, 2);
        map_check(15, 28, 2);
        map_check(15, 29, 2);
        map_check(0, 0, 2);
        map_check(4, 16, 2);
        map_check(3, 16, 2);
        map_check(16, 5, 2);
        map_check(20, 12, 2);

        // R9 start without lock
        cdr_lock = 1'b0;
        exp_q.push_back(nl);
        begin
            int d0;
            d0 = done_cnt;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(!busy, "R9 busy stays low", int'(busy), 0);
            @(negedge clk);
            chk(done_cnt == d0 + 1, "R9 done two cycles after start", done_cnt - d0, 1);
        end
        repeat (3) @(negedge clk);
        cdr_lock = 1'b1;

        // R10 lock lost mid-scan
        exp_q.push_back(nl);
        begin
            int d0;
            d0 = done_cnt;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (3000) @(negedge clk);
            chk(busy, "R10 busy before lock loss", int'(busy), 1);
            cdr_lock = 1'b0;
            repeat (2) @(negedge clk);
            chk(!busy, "R10 busy dropped", int'(busy), 0);
            repeat (3) @(negedge clk);
            chk(done_cnt == d0 + 1, "R10 done after abort", done_cnt - d0, 1);
        end
        cdr_lock = 1'b1;
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2 every scan reported", exp_q.size(), 0);
        summary();
    end

endmodule